// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column address stream for one burst of a synchronous DRAM controller. A request strobe captures a starting column, a length code, an ordering select and a direction. From the next clock on, the block presents one column address per cycle with a valid flag. It also raises a flag on the final beat of a fixed-length burst.

A burst can be cut short with a halt input. A new request can be issued on any cycle; it drops the burst in flight and starts the new sequence in its place. Two orderings are offered. Linear order counts the low column bits upward and wraps inside the aligned block. Interleaved order XORs the beat index into the low bits. The page length walks the entire row and wraps past the last column, with no end of its own.

A one-shot write mode forces every write request down to a single beat, whatever its length code says. Read requests keep their coded length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_vld_o` and `beat_end_o` are low until a request is accepted.
- R2: A legal request sampled on a rising edge makes `beat_vld_o` high on the next cycle, with `col_o` equal to the requested start column. One new address follows on every clock while the burst runs.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `beat_vld_o` falls in the cycle after the last beat.
- R4: With `ilv_i`=0, beat k of an N-beat burst keeps the column bits above the low log2(N) bits equal to the start column. The low bits equal (start low bits + k) mod N.
- R5: With `ilv_i`=1, beat k of an N-beat burst keeps the upper bits and sets the low log2(N) bits to (start low bits XOR k).
- R6: Length code 3'b111 with `ilv_i`=0 is page mode. The column increases by one per beat modulo 256, `beat_end_o` never rises, and the burst runs until a halt or a new request.
- R7: Codes 3'b100, 3'b101 and 3'b110 are reserved for any ordering, and 3'b111 is reserved with `ilv_i`=1. A request carrying a reserved code stops any burst in flight, and `beat_vld_o` is low on the next cycle.
- R8: `beat_end_o` is high only together with `beat_vld_o`, and only on the final beat of a fixed-length burst.
- R9: `halt_i` high without `req_i` makes `beat_vld_o` low on the next cycle. When both are high, the request wins.
- R10: A legal request during a running burst begins the new sequence on the next cycle from the new start column.
- R11: With `one_shot_wr_i`=1, a request with `is_wr_i`=1 yields exactly one beat with `beat_end_o` high, for any length code including reserved ones. A request with `is_wr_i`=0 keeps its coded length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Burst request strobe |
| start_col_i | input | COL_W (8) | Starting column of the request |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 linear order, 1 interleaved order |
| one_shot_wr_i | input | 1 | Writes use a single beat when 1 |
| is_wr_i | input | 1 | Request is a write |
| halt_i | input | 1 | End the running burst |
| col_o | output | COL_W (8) | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| beat_end_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its defaults: an 8-bit column and a longest fixed burst of 2^3 beats. At this size, page mode can be driven across the wrap from column 255 to 0 within a few beats. Start columns with odd low bits show the wrap inside a 4- or 8-beat block, in both orderings. Every length code, including each reserved one, fits into a handful of directed cases.

// File: rtl/bcag_pkg.sv
package bcag_pkg;
    localparam logic [2:0] LEN_C1   = 3'b000;
    localparam logic [2:0] LEN_C2   = 3'b001;
    localparam logic [2:0] LEN_C4   = 3'b010;
    localparam logic [2:0] LEN_C8   = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/bcag_len_decode.sv
module bcag_len_decode
    import bcag_pkg::*;
#(
    parameter int COL_W    = 8,
    parameter int MAX_LOG2 = 3
) (
    input  logic [2:0]       code_i,
    input  logic             ilv_i,
    input  logic             one_shot_wr_i,
    input  logic             is_wr_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             legal_o
);
    // Wrap mask: ones over the low bits that cycle inside the burst block
    always_comb begin
        mask_o  = '0;
        page_o  = 1'b0;
        legal_o = 1'b0;
        if (one_shot_wr_i && is_wr_i) begin
            legal_o = 1'b1;
        end else if (code_i == LEN_PAGE) begin
            if (order_e'(ilv_i) == ORD_LINEAR) begin
                legal_o = 1'b1;
                page_o  = 1'b1;
                mask_o  = '1;
            end
        end else if (int'(code_i) <= MAX_LOG2) begin
            legal_o = 1'b1;
            mask_o  = (COL_W'(1) << code_i) - COL_W'(1);
        end
    end
endmodule

// File: rtl/bcag_col_order.sv
module bcag_col_order
    import bcag_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_val;

    assign lin_sum = base_i + idx_i;
    assign xor_val = base_i ^ idx_i;

    // Per-bit select: bits inside the wrap mask take the ordered value
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b]
                        ? ((order_e'(ilv_i) == ORD_XOR) ? xor_val[b] : lin_sum[b])
                        : base_i[b];
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcag_pkg::*;
#(
    parameter int COL_W    = 8,
    parameter int MAX_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             one_shot_wr_i,
    input  logic             is_wr_i,
    input  logic             halt_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             beat_end_o
);
    typedef struct packed {
        logic             run;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
        logic             ilv;
        logic             page;
        logic [COL_W-1:0] col;
        logic             fin;
    } seq_t;

    seq_t s_d, s_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_legal;

    bcag_len_decode #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) dec_i (
        .code_i        (len_code_i),
        .ilv_i         (ilv_i),
        .one_shot_wr_i (one_shot_wr_i),
        .is_wr_i       (is_wr_i),
        .mask_o        (dec_mask),
        .page_o        (dec_page),
        .legal_o       (dec_legal)
    );

    logic [COL_W-1:0] idx_inc;
    logic [COL_W-1:0] ord_base;
    logic [COL_W-1:0] ord_idx;
    logic [COL_W-1:0] ord_mask;
    logic             ord_ilv;
    logic [COL_W-1:0] ord_col;

    assign idx_inc = s_q.idx + COL_W'(1);

    // Operand select: a new request computes beat 0, otherwise the next beat
    always_comb begin
        if (req_i) begin
            ord_base = start_col_i;
            ord_idx  = '0;
            ord_mask = dec_mask;
            ord_ilv  = ilv_i;
        end else begin
            ord_base = s_q.base;
            ord_idx  = idx_inc;
            ord_mask = s_q.mask;
            ord_ilv  = s_q.ilv;
        end
    end

    bcag_col_order #(.COL_W(COL_W)) ord_i (
        .base_i (ord_base),
        .idx_i  (ord_idx),
        .mask_i (ord_mask),
        .ilv_i  (ord_ilv),
        .col_o  (ord_col)
    );

    always_comb begin
        s_d = s_q;
        if (req_i) begin
            if (dec_legal) begin
                s_d.run  = 1'b1;
                s_d.base = start_col_i;
                s_d.idx  = '0;
                s_d.mask = dec_mask;
                s_d.ilv  = ilv_i;
                s_d.page = dec_page;
                s_d.col  = ord_col;
                s_d.fin  = !dec_page && (dec_mask == '0);
            end else begin
                s_d.run = 1'b0;
                s_d.fin = 1'b0;
            end
        end else if (halt_i) begin
            s_d.run = 1'b0;
            s_d.fin = 1'b0;
        end else if (s_q.run) begin
            if (s_q.fin) begin
                s_d.run = 1'b0;
                s_d.fin = 1'b0;
            end else begin
                s_d.idx = idx_inc;
                s_d.col = ord_col;
                s_d.fin = !s_q.page && (idx_inc == s_q.mask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign col_o      = s_q.col;
    assign beat_vld_o = s_q.run;
    assign beat_end_o = s_q.fin;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             ilv_i,
    input logic             one_shot_wr_i,
    input logic             is_wr_i,
    input logic             halt_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             beat_end_o
);
    logic wr_single;
    logic code_ok;
    assign wr_single = one_shot_wr_i && is_wr_i;
    assign code_ok   = wr_single || (len_code_i <= 3'b011)
                    || (len_code_i == 3'b111 && !ilv_i);

    // R8
    end_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_end_o |-> beat_vld_o);

    // R2
    start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && code_ok |=> beat_vld_o && col_o == $past(start_col_i));

    // R9
    halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i && !req_i |=> !beat_vld_o);

    // R3
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_end_o && !req_i |=> !beat_vld_o);

    // R7
    reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !code_ok |=> !beat_vld_o);

    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && !beat_end_o && !req_i && !halt_i |=> beat_vld_o);

    // R11
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && wr_single |=> beat_end_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .start_col_i   (start_col_i),
    .len_code_i    (len_code_i),
    .ilv_i         (ilv_i),
    .one_shot_wr_i (one_shot_wr_i),
    .is_wr_i       (is_wr_i),
    .halt_i        (halt_i),
    .col_o         (col_o),
    .beat_vld_o    (beat_vld_o),
    .beat_end_o    (beat_end_o)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       one_shot_wr_i = 1'b0;
    logic       is_wr_i = 1'b0;
    logic       halt_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       beat_end_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .one_shot_wr_i(one_shot_wr_i),
        .is_wr_i(is_wr_i), .halt_i(halt_i), .col_o(col_o),
        .beat_vld_o(beat_vld_o), .beat_end_o(beat_end_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int b, input int k, input int n, input bit x);
        int lo = b % n;
        int hi = b - lo;
        if (x) return hi + (lo ^ (k % n));
        return hi + ((lo + k) % n);
    endfunction

    task automatic issue(input int b, input int code, input bit x, input bit sw, input bit wr);
        req_i = 1'b1; start_col_i = 8'(b); len_code_i = 3'(code);
        ilv_i = x; one_shot_wr_i = sw; is_wr_i = wr;
    endtask

    task automatic check_beats(input string req, input int b, input int n, input bit x,
                               input int cnt, input bit page);
        for (int k = 0; k < cnt; k++) begin
            check({req, " vld"}, int'(beat_vld_o), 1);
            check({req, " col"}, int'(col_o), exp_col(b, k, n, x));
            check({req, " end"}, int'(beat_end_o), (!page && k == n - 1) ? 1 : 0);
            if (k < cnt - 1) @(negedge clk);
        end
    endtask

    // Full fixed-length burst, then confirm valid drops
    task automatic run_fixed(input string req, input int b, input int code, input bit x,
                             input bit sw, input bit wr, input int n);
        @(negedge clk); issue(b, code, x, sw, wr);
        @(negedge clk); req_i = 1'b0;
        check_beats(req, b, n, x, n, 1'b0);
        @(negedge clk);
        check({req, " drop"}, int'(beat_vld_o), 0);
    endtask

    task automatic t_reset;
        // R1
        check("R1 vld", int'(beat_vld_o), 0);
        check("R1 end", int'(beat_end_o), 0);
    endtask

    task automatic t_page;
        // R6: wrap from 255 to 0, no end flag, runs until halt
        @(negedge clk); issue(8'hFD, 7, 1'b0, 1'b0, 1'b0);
        @(negedge clk); req_i = 1'b0;
        check_beats("R6 page", 8'hFD, 256, 1'b0, 12, 1'b1);
        halt_i = 1'b1;
        @(negedge clk); halt_i = 1'b0;
        check("R6 R9 halt page", int'(beat_vld_o), 0);
    endtask

    task automatic t_halt;
        // R9: halt mid-burst, and request beating halt in the same cycle
        @(negedge clk); issue(8'h20, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk); req_i = 1'b0;
        check_beats("R9 pre", 8'h20, 8, 1'b0, 3, 1'b0);
        halt_i = 1'b1;
        @(negedge clk); halt_i = 1'b0;
        check("R9 halt", int'(beat_vld_o), 0);
        @(negedge clk);
        check("R9 stays", int'(beat_vld_o), 0);
        issue(8'h66, 1, 1'b0, 1'b0, 1'b0); halt_i = 1'b1;
        @(negedge clk); req_i = 1'b0; halt_i = 1'b0;
        check_beats("R9 req wins", 8'h66, 2, 1'b0, 2, 1'b0);
        @(negedge clk);
        check("R9 after", int'(beat_vld_o), 0);
    endtask

    task automatic t_restart;
        // R10: new request mid-burst replaces the sequence
        @(negedge clk); issue(8'h10, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk); req_i = 1'b0;
        check_beats("R10 first", 8'h10, 8, 1'b0, 3, 1'b0);
        issue(8'h47, 2, 1'b1, 1'b0, 1'b0);
        @(negedge clk); req_i = 1'b0;
        check_beats("R10 second", 8'h47, 4, 1'b1, 4, 1'b0);
        @(negedge clk);
        check("R10 drop", int'(beat_vld_o), 0);
    endtask

    task automatic t_reserved;
        // R7: reserved code mid-burst aborts; reserved codes from idle give nothing
        @(negedge clk); issue(8'h30, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk); req_i = 1'b0;
        check_beats("R7 pre", 8'h30, 8, 1'b0, 2, 1'b0);
        issue(8'h55, 4, 1'b0, 1'b0, 1'b0);
        @(negedge clk); req_i = 1'b0;
        check("R7 abort 100", int'(beat_vld_o), 0);
        for (int c = 5; c <= 7; c++) begin
            issue(8'h12, c, 1'b1, 1'b0, 1'b0);
            @(negedge clk); req_i = 1'b0;
            check("R7 idle reserved", int'(beat_vld_o), 0);
            @(negedge clk);
            check("R7 idle reserved later", int'(beat_vld_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_fixed("R2 R3 len1", 8'hA7, 0, 1'b0, 1'b0, 1'b0, 1);
        run_fixed("R3 R4 len2", 8'h0B, 1, 1'b0, 1'b0, 1'b0, 2);
        run_fixed("R4 len4 wrap", 8'h1E, 2, 1'b0, 1'b0, 1'b0, 4);
        run_fixed("R4 R8 len8", 8'h35, 3, 1'b0, 1'b0, 1'b0, 8);
        run_fixed("R5 ilv8", 8'h35, 3, 1'b1, 1'b0, 1'b0, 8);
        run_fixed("R5 ilv4", 8'hC9, 2, 1'b1, 1'b0, 1'b0, 4);
        run_fixed("R5 ilv2", 8'h7F, 1, 1'b1, 1'b0, 1'b0, 2);
        t_page();
        t_halt();
        t_restart();
        t_reserved();
        run_fixed("R11 wr one", 8'h44, 3, 1'b0, 1'b1, 1'b1, 1);
        run_fixed("R11 wr reserved", 8'h45, 5, 1'b1, 1'b1, 1'b1, 1);
        run_fixed("R11 rd keeps", 8'h46, 3, 1'b0, 1'b1, 1'b0, 8);
        run_fixed("R11 off wr", 8'h48, 2, 1'b0, 1'b0, 1'b1, 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule